// File: doc/BRIEF.md
# Dot Clock Generator and Plane Pixel Serializer

This block sits on the display side of a bit-plane video controller. It takes the master video clock and derives two enables from it. The dot enable marks each displayed pixel. The character enable marks the last dot of each character cell. For every fetched character it loads four plane shift registers, one per bit plane. It then shifts out one pixel per dot enable, made of one bit from each plane, starting from the most significant bit.

Two write-only registers, reached through an index/data write port, control the block: a run-control register and a clocking-mode register. The clocking-mode register sets:
- the character cell width: 8 or 9 dots;
- the dot rate: the master rate or half of it;
- the serializer reload rate: every character or every other character, with 16 bits chained per plane;
- the number of CRT memory-fetch slots in each five-cycle window: 4 or 2.

Downstream arbitration logic uses the fetch-slot output to decide which memory cycles belong to the display.

Top module: `vid_dot_serializer`

## Requirements
- R1: Clocking-mode bit 0 (index 1) selects the cell width: 0 gives 9 dots per character, 1 gives 8. `char_en` pulses together with `dot_en` on the last dot of each cell.
- R2: Clocking-mode bit 3 = 0 makes `dot_en` high on every running master cycle. Bit 3 = 1 makes it high on every second running cycle, starting with the second cycle after release.
- R3: Clocking-mode bit 2 controls reloading.
  - With bit 2 = 0, the shifters load on dot 0 of every character and use bits [15:8] of each plane's 16-bit word.
  - With bit 2 = 1, they load on dot 0 of every other character (characters 0, 2, 4, … after release) and shift the whole 16-bit word, bit 15 first, across two cells.
- R4: `crt_slot` follows a five-state counter that starts at state 0 on the first running cycle. With clocking-mode bit 1 = 0 it is high in states 0–3. With bit 1 = 1 it is high in states 0 and 2 only.
- R5: Run-control register (index 0) bit 1 = 0 halts the block.
  - From the cycle after the write, `dot_en`, `char_en`, `load_stb` and `crt_slot` are 0.
  - One cycle later, `pixel` is 0.
  - When both run bits return to 1, all counters restart from zero.
- R6: Run-control bit 0 = 0 also halts, and forces `pixel` to 0 in the very cycle after the write.
- R7: `pixel` = {plane3, plane2, plane1, plane0}, where plane p occupies `plane_data[16p+15:16p]`. The pixel for a dot appears in the master cycle that follows that dot's `dot_en` cycle. The first dot after release loads and shows the top bit.
- R8: In a 9-dot cell the ninth dot shows pixel 0, and the shifters keep their contents through it.
- R9: Register port behaviour:
  - A write with `reg_sel_index` = 1 sets the index.
  - A data write lands in the run-control register at index 0 or the clocking-mode register at index 1. At any other index it has no effect.
  - After reset, both registers are 0: halted, 9-dot cells, full dot rate, reload every character, 4 of 5 slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master video clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel_index | input | 1 | 1: write the index; 0: write the register at the index |
| reg_wdata | input | 8 | Write data |
| plane_data | input | 64 | Four 16-bit plane words; plane p at bits [16p+15:16p] |
| dot_en | output | 1 | Dot clock enable |
| char_en | output | 1 | Character clock enable (last dot of a cell) |
| load_stb | output | 1 | Shifters sample `plane_data` at the end of this cycle |
| pixel | output | 4 | Current pixel {plane3..plane0} |
| crt_slot | output | 1 | Memory cycle reserved for display fetch |

## Verification
The embedded assertions check local timing rules on every cycle:
- the half-rate dot enable never fires on two cycles in a row;
- character enables never fire back to back;
- the two-of-five slot pattern never gives adjacent slots;
- the cycle after a ninth dot is dark;
- a data write never moves the index.

Only the bench scenarios can show the full shifted pixel stream, with its bit order, the chained 16-bit reload across two cells and the plane-to-bit mapping. The same holds for:
- the enable counts over a window for each mode;
- the slot phase after release;
- the one-cycle difference between the two halt bits;
- the fact that writes to unused indices leave a running stream undisturbed.

// File: rtl/vds_pkg.sv
package vds_pkg;
   localparam int unsigned IDX_RUNCTL  = 0;
   localparam int unsigned IDX_CLKMODE = 1;

   // Field order matches the bit positions of the clocking-mode register.
   typedef struct packed {
      logic dot_half;    // bit 3
      logic chain_load;  // bit 2
      logic low_bw;      // bit 1
      logic narrow;      // bit 0
   } clk_mode_t;
endpackage

// File: rtl/vds_regs.sv
module vds_regs
   import vds_pkg::*;
#(
   parameter int unsigned IDX_W = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic       sel_index,
   input  logic [7:0] wdata,
   output clk_mode_t  mode,
   output logic       run,
   output logic       pix_gate
);
   logic [IDX_W-1:0] idx_q;
   logic [1:0]       runctl_q;
   clk_mode_t        mode_q;
   logic             unused_wbits;

   initial begin : p_param_chk
      assert (IDX_W >= 1 && IDX_W <= 8) else $error("IDX_W must be 1..8");
   end

   assign unused_wbits = ^{wdata, 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q    <= '0;
         runctl_q <= '0;
         mode_q   <= '0;
      end else if (wr) begin
         if (sel_index) begin
            idx_q <= wdata[IDX_W-1:0];
         end else if (idx_q == IDX_W'(IDX_RUNCTL)) begin
            runctl_q <= wdata[1:0];
         end else if (idx_q == IDX_W'(IDX_CLKMODE)) begin
            mode_q <= clk_mode_t'(wdata[3:0]);
         end
      end
   end

   assign mode     = mode_q;
   assign run      = &runctl_q;
   assign pix_gate = runctl_q[0];

   // R9: a data write never disturbs the index
   a_r9_index_kept : assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !sel_index) |=> $stable(idx_q));
endmodule

// File: rtl/vds_timing.sv
module vds_timing
   import vds_pkg::*;
#(
   parameter int unsigned CHAR_W   = 8,
   parameter int unsigned SLOTS    = 5,
   parameter int unsigned CRT_FULL = 4,
   parameter int unsigned CRT_LOW  = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      run,
   input  clk_mode_t mode,
   output logic      dot_en,
   output logic      char_en,
   output logic      load_en,
   output logic      blank_dot,
   output logic      crt_slot
);
   localparam int unsigned CNT_W  = $clog2(CHAR_W + 1);
   localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
   localparam logic [CNT_W-1:0]  LAST_NARROW = CNT_W'(CHAR_W - 1);
   localparam logic [CNT_W-1:0]  LAST_WIDE   = CNT_W'(CHAR_W);
   localparam logic [SLOT_W-1:0] SLOT_END    = SLOT_W'(SLOTS - 1);

   initial begin : p_param_chk
      assert (CHAR_W >= 2) else $error("CHAR_W too small");
      assert (CRT_FULL <= SLOTS) else $error("CRT_FULL exceeds SLOTS");
      assert (2 * CRT_LOW <= SLOTS + 1) else $error("CRT_LOW does not fit");
   end

   logic             div_q;
   logic [CNT_W-1:0] dot_q;
   logic [CNT_W-1:0] dot_last;
   logic             phase_q;
   logic [SLOT_W-1:0] slot_q;
   logic [SLOTS-1:0] full_map;
   logic [SLOTS-1:0] low_map;
   logic             at_last;

   // dot rate divider
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_q <= 1'b0;
      else if (!run)   div_q <= 1'b0;
      else             div_q <= ~div_q;
   end

   assign dot_en   = run && (!mode.dot_half || div_q);
   assign dot_last = mode.narrow ? LAST_NARROW : LAST_WIDE;
   assign at_last  = (dot_q >= dot_last);

   // dot position within the character cell
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dot_q <= '0;
      else if (!run)   dot_q <= '0;
      else if (dot_en) dot_q <= at_last ? '0 : dot_q + 1'b1;
   end

   // even/odd character phase for chained reloads
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase_q <= 1'b0;
      else if (!run)    phase_q <= 1'b0;
      else if (char_en) phase_q <= ~phase_q;
   end

   assign char_en   = dot_en && at_last;
   assign load_en   = dot_en && (dot_q == '0) && (!mode.chain_load || !phase_q);
   assign blank_dot = (dot_q == LAST_WIDE);

   // memory slot window
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  slot_q <= '0;
      else if (!run)               slot_q <= '0;
      else if (slot_q >= SLOT_END) slot_q <= '0;
      else                         slot_q <= slot_q + 1'b1;
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot_map
      assign full_map[s] = (s < CRT_FULL);
      assign low_map[s]  = ((s % 2) == 0) && ((s / 2) < CRT_LOW);
   end

   assign crt_slot = run && (mode.low_bw ? low_map[slot_q] : full_map[slot_q]);

   // R2: at half rate two dot enables are never adjacent
   a_r2_half_gap : assert property (@(posedge clk) disable iff (!rst_n)
      (dot_en && mode.dot_half) |=> (!dot_en || !mode.dot_half));

   // R1: a cell is at least two dots, so char enables never touch
   a_r1_char_gap : assert property (@(posedge clk) disable iff (!rst_n)
      char_en |=> !char_en);

   // R4: in two-of-five mode the slots are separated
   a_r4_low_spacing : assert property (@(posedge clk) disable iff (!rst_n)
      (crt_slot && mode.low_bw) |=> (!crt_slot || !mode.low_bw));

   // R5: a halted cycle leaves the cell counter at zero
   a_r5_halt_clears : assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (dot_q == '0));
endmodule

// File: rtl/vds_shifter.sv
module vds_shifter #(
   parameter int unsigned NPLANES  = 4,
   parameter int unsigned BYTE_W   = 8,
   parameter bit          CHAIN_EN = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          run,
   input  logic                          pix_gate,
   input  logic                          dot_en,
   input  logic                          load_en,
   input  logic                          blank_dot,
   input  logic                          chain,
   input  logic [NPLANES*2*BYTE_W-1:0]   plane_data,
   output logic [NPLANES-1:0]            pixel
);
   localparam int unsigned WORD_W = 2 * BYTE_W;

   logic [NPLANES-1:0] pix_raw;

   for (genvar p = 0; p < NPLANES; p++) begin : g_plane
      logic [WORD_W-1:0] word;
      logic [WORD_W-1:0] ld_word;
      logic [WORD_W-1:0] sh_q;
      logic              bit_q;

      assign word = plane_data[p*WORD_W +: WORD_W];

      if (CHAIN_EN) begin : g_chain
         assign ld_word = chain ? word : {word[WORD_W-1 -: BYTE_W], {BYTE_W{1'b0}}};
      end else begin : g_single
         logic unused_chain;
         assign unused_chain = chain;
         assign ld_word = {word[WORD_W-1 -: BYTE_W], {BYTE_W{1'b0}}};
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_q  <= '0;
            bit_q <= 1'b0;
         end else if (!run) begin
            sh_q  <= '0;
            bit_q <= 1'b0;
         end else if (dot_en) begin
            if (load_en) begin
               bit_q <= ld_word[WORD_W-1];
               sh_q  <= {ld_word[WORD_W-2:0], 1'b0};
            end else if (blank_dot) begin
               bit_q <= 1'b0;
            end else begin
               bit_q <= sh_q[WORD_W-1];
               sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
            end
         end
      end

      assign pix_raw[p] = bit_q;
   end

   assign pixel = pix_gate ? pix_raw : '0;

   // R8: the dot after a ninth-dot enable is dark
   a_r8_ninth_dark : assert property (@(posedge clk) disable iff (!rst_n)
      (dot_en && blank_dot && !load_en) |=> (pixel == '0));

   // R6: a cleared gate bit darkens the output at once
   a_r6_gate_dark : assert property (@(posedge clk) disable iff (!rst_n)
      !pix_gate |-> (pixel == '0));
endmodule

// File: rtl/vid_dot_serializer.sv
module vid_dot_serializer
   import vds_pkg::*;
#(
   parameter int unsigned NPLANES  = 4,
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned IDX_W    = 5,
   parameter int unsigned SLOTS    = 5,
   parameter int unsigned CRT_FULL = 4,
   parameter int unsigned CRT_LOW  = 2,
   parameter bit          CHAIN_EN = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reg_wr,
   input  logic                        reg_sel_index,
   input  logic [7:0]                  reg_wdata,
   input  logic [NPLANES*2*BYTE_W-1:0] plane_data,
   output logic                        dot_en,
   output logic                        char_en,
   output logic                        load_stb,
   output logic [NPLANES-1:0]          pixel,
   output logic                        crt_slot
);
   clk_mode_t mode_reg;
   clk_mode_t mode_eff;
   logic      run;
   logic      pix_gate;
   logic      blank_dot;

   vds_regs #(.IDX_W(IDX_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (reg_wr),
      .sel_index (reg_sel_index),
      .wdata     (reg_wdata),
      .mode      (mode_reg),
      .run       (run),
      .pix_gate  (pix_gate)
   );

   always_comb begin
      mode_eff = mode_reg;
      if (!CHAIN_EN) mode_eff.chain_load = 1'b0;
   end

   vds_timing #(
      .CHAR_W   (BYTE_W),
      .SLOTS    (SLOTS),
      .CRT_FULL (CRT_FULL),
      .CRT_LOW  (CRT_LOW)
   ) u_timing (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .mode      (mode_eff),
      .dot_en    (dot_en),
      .char_en   (char_en),
      .load_en   (load_stb),
      .blank_dot (blank_dot),
      .crt_slot  (crt_slot)
   );

   vds_shifter #(
      .NPLANES  (NPLANES),
      .BYTE_W   (BYTE_W),
      .CHAIN_EN (CHAIN_EN)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .pix_gate   (pix_gate),
      .dot_en     (dot_en),
      .load_en    (load_stb),
      .blank_dot  (blank_dot),
      .chain      (mode_eff.chain_load),
      .plane_data (plane_data),
      .pixel      (pixel)
   );

   // R5: nothing is strobed while halted
   a_r5_quiet_halt : assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (!dot_en && !load_stb && !crt_slot));
endmodule

// File: tb/test_vid_dot_serializer.sv
module test_vid_dot_serializer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_sel_index = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [63:0] plane_data = '0;
   logic        dot_en, char_en, load_stb, crt_slot;
   logic [3:0]  pixel;

   int checks = 0;
   int fails  = 0;
   logic [3:0] exp_q[$];
   int  ld_cnt = 0;
   bit  pend   = 0;
   bit  prev_dot = 0;

   always #2.5 clk = ~clk;

   vid_dot_serializer i_vid_dot_serializer (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel_index(reg_sel_index),
      .reg_wdata(reg_wdata), .plane_data(plane_data), .dot_en(dot_en),
      .char_en(char_en), .load_stb(load_stb), .pixel(pixel), .crt_slot(crt_slot)
   );

   function automatic logic [15:0] gen(int j, int p);
      logic [31:0] t;
      t = (j + 1) * 32'h3B71 + (p + 3) * 32'h0A5D;
      return t[15:0] ^ 16'h5AC3;
   endfunction

   function automatic logic [63:0] gen_all(int j);
      logic [63:0] v;
      for (int p = 0; p < 4; p++) v[p*16 +: 16] = gen(j, p);
      return v;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // scoreboard monitor: compare each dot's pixel in the cycle after its enable
   always @(negedge clk) begin
      if (pend) begin
         ld_cnt++;
         plane_data = gen_all(ld_cnt);
         pend = 0;
      end
      if (prev_dot && exp_q.size() > 0) begin
         logic [3:0] e;
         e = exp_q.pop_front();
         chk(pixel == e, "R7/R3/R8 pixel stream", int'(pixel), int'(e));
      end
      prev_dot = dot_en;
      if (load_stb) pend = 1;
   end

   task automatic wr_index(logic [7:0] v);
      @(negedge clk);
      reg_wr = 1; reg_sel_index = 1; reg_wdata = v;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic wr_data(logic [7:0] v);
      @(negedge clk);
      reg_wr = 1; reg_sel_index = 0; reg_wdata = v;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic write_reg(logic [7:0] idx, logic [7:0] v);
      wr_index(idx);
      wr_data(v);
   endtask

   // driver: pushes the expected pixel stream for a mode
   task automatic push_expected(logic [3:0] m, int nchars);
      bit narrow = m[0];
      bit chain  = m[2];
      for (int c = 0; c < nchars; c++) begin
         int j    = chain ? c / 2 : c;
         int base = (chain && (c % 2 == 1)) ? 7 : 15;
         for (int k = 0; k < 8; k++) begin
            logic [3:0] px;
            for (int p = 0; p < 4; p++) px[p] = gen(j, p)[base - k];
            exp_q.push_back(px);
         end
         if (!narrow) exp_q.push_back(4'h0);
      end
   endtask

   task automatic run_mode(logic [3:0] m, int nchars, bit poke);
      int dots = 0, chars = 0, loads = 0, width, edots, echars, estart, eloads;
      write_reg(8'd0, 8'h01);
      write_reg(8'd1, {4'h0, m});
      ld_cnt = 0; pend = 0;
      plane_data = gen_all(0);
      exp_q.delete();
      push_expected(m, nchars);
      write_reg(8'd0, 8'h03);
      // now in the first running cycle
      for (int i = 0; i < 40; i++) begin
         if (i < 10) begin
            bit es = m[1] ? ((i % 5) == 0 || (i % 5) == 2) : ((i % 5) != 4);
            chk(crt_slot == es, "R4 slot pattern", int'(crt_slot), int'(es));
         end
         dots  += int'(dot_en);
         chars += int'(char_en);
         loads += int'(load_stb);
         @(negedge clk);
      end
      width  = m[0] ? 8 : 9;
      edots  = m[3] ? 20 : 40;
      echars = edots / width;
      estart = (edots + width - 1) / width;
      eloads = m[2] ? (estart + 1) / 2 : estart;
      chk(dots == edots, "R2 dot enable count", dots, edots);
      chk(chars == echars, "R1 char enable count", chars, echars);
      chk(loads == eloads, "R3 load strobe count", loads, eloads);
      if (poke) begin
         // R9: writes at an unused index must leave the stream intact
         write_reg(8'd2, 8'h00);
         write_reg(8'd5, 8'h0F);
      end
      for (int w = 0; w < 2000 && exp_q.size() > 0; w++) @(negedge clk);
      chk(exp_q.size() == 0, "R7 stream completed", exp_q.size(), 0);
      // R5: synchronous halt
      write_reg(8'd0, 8'h01);
      chk(dot_en == 0 && load_stb == 0, "R5 strobes stop", int'(dot_en), 0);
      chk(crt_slot == 0, "R5 slot stops", int'(crt_slot), 0);
      @(negedge clk);
      chk(pixel == 0, "R5 pixel cleared", int'(pixel), 0);
   endtask

   initial begin : watchdog
      #(200000 * 5);
      checks++; fails++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R9: reset leaves the block halted
      chk(pixel == 0, "R9 reset pixel", int'(pixel), 0);
      chk(dot_en == 0, "R9 reset dot_en", int'(dot_en), 0);
      chk(crt_slot == 0, "R9 reset crt_slot", int'(crt_slot), 0);
      chk(load_stb == 0 && char_en == 0, "R9 reset strobes", int'(load_stb), 0);
      write_reg(8'd1, 8'h01);   // mode write alone must not start it
      repeat (3) @(negedge clk);
      chk(dot_en == 0, "R9 still halted", int'(dot_en), 0);

      run_mode(4'h1, 6, 0);   // 8-dot, full rate, every char, 4 of 5
      run_mode(4'h0, 6, 0);   // 9-dot cells
      run_mode(4'hB, 4, 0);   // half rate, 2 of 5, 8-dot
      run_mode(4'h4, 6, 0);   // chained 16 bits, 9-dot
      run_mode(4'h5, 6, 1);   // chained, 8-dot, unused-index writes
      run_mode(4'h8, 3, 0);   // half rate, 9-dot

      // R6: asynchronous halt bit darkens at once
      write_reg(8'd1, 8'h01);
      exp_q.delete();
      ld_cnt = 0; pend = 0; plane_data = gen_all(0);
      write_reg(8'd0, 8'h03);
      for (int w = 0; w < 64 && pixel == 0; w++) @(negedge clk);
      chk(pixel != 0, "R6 precondition lit", int'(pixel), 1);
      wr_data(8'h02);
      chk(pixel == 0, "R6 pixel dark next cycle", int'(pixel), 0);
      chk(dot_en == 0, "R6 dot_en stopped", int'(dot_en), 0);
      repeat (2) @(negedge clk);
      chk(pixel == 0, "R6 pixel stays dark", int'(pixel), 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule